// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a destination operand left or right by a count. The bit positions it vacates are filled from a second, source operand rather than with zeros. The two operands are treated as one joined bit string. For a left shift the source sits below the destination, so its top bits enter the low end of the result. For a right shift the source sits above the destination, so its low bits enter the high end. Only the destination value is produced as the result, and the source is never written. The carry output records the last destination bit pushed out of the operand.

The operand size is chosen per operation, either full width (32 bits) or half width (16 bits). The count arrives as a raw byte, which may be an immediate or the contents of a count register. Only its low five bits are used. A zero count leaves the destination and the carry untouched. A half-width count larger than the operand size is an error: the result is the unchanged destination, the carry is held and an error flag is raised. Results are registered and marked by a one-cycle valid pulse.

Top module: `dfunnel_shifter`

## Requirements
- R1: With `dir_i`=0 (left) and masked count k≥1, the result is the destination moved up by k, with its low k bits taken from the top k bits of the source operand.
- R2: With `dir_i`=1 (right) and masked count k≥1, the result is the destination moved down by k, with its high k bits taken from the low k bits of the source operand.
- R3: On a left shift by k≥1 at width W, `carry_o` becomes destination bit W−k (for example 0x01234567 with source 0x89ABCDEF, left by 8: result 0x23456789, carry 1).
- R4: On a right shift by k≥1, `carry_o` becomes destination bit k−1 (same operands, right by 8: result 0xEF012345, carry 0).
- R5: Only bits [4:0] of `cnt_i` form the count; bits [7:5] have no effect.
- R6: A masked count of zero yields the destination unchanged as the result and leaves `carry_o` at its previous value.
- R7: With `size32_i`=0, only bits [15:0] of both operands take part, result bits [31:16] are zero, and a count of exactly 16 is a valid shift.
- R8: With `size32_i`=0 and masked count above 16, the result is destination bits [15:0] zero-extended, `carry_o` holds and `err_o` is 1; every other accepted operation clears `err_o`.
- R9: `out_valid` is high exactly in the cycle after an accepted `in_valid`; `res_o`, `carry_o` and `err_o` change only on such an update and hold otherwise.
- R10: Synchronous active-low reset clears `out_valid`, `res_o`, `carry_o` and `err_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| size32_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| cnt_i | input | 8 | Raw shift count; low five bits used |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand supplying fill bits |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| res_o | output | 32 | New destination value |
| carry_o | output | 1 | Last destination bit shifted out |
| err_o | output | 1 | Half-width count out of range |

## Verification
A wrong fill path shows up first at `res_o`, in the cycle after the request, as a wrong slice of bits at the filled end. A wrong carry index appears as a flipped `carry_o`. Held carry state is the only memory the block keeps across operations. A fault there stays hidden until a zero-count or out-of-range operation, which must return the carry of the previous operation. For that reason those cases are placed directly behind operations that leave the carry at a known non-zero value.

// File: rtl/fsh_pkg.sv
// Package: shared encodings for the funnel shifter.
// Assumes: single-bit direction code, count flags used by core and top.
package fsh_pkg;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } sh_dir_e;

    typedef struct packed {
        logic zero;      // masked count is zero
        logic over_half; // masked count exceeds half width
    } cnt_flags_t;

endpackage

// File: rtl/fsh_count.sv
// Module: fsh_count
// Masks the raw count to its low bits and classifies it.
// Assumes: CNT_IN_W >= CNT_W; HALF is the narrow operand width.
module fsh_count
    import fsh_pkg::*;
#(
    parameter int CNT_IN_W = 8,
    parameter int CNT_W    = 5,
    parameter int HALF     = 16
) (
    input  logic [CNT_IN_W-1:0] cnt_raw,
    output logic [CNT_W-1:0]    k,
    output cnt_flags_t          flags
);

    logic unused_cnt_hi;

    // Keep the low count bits; the upper bits are discarded by definition.
    always_comb begin
        k               = cnt_raw[CNT_W-1:0];
        unused_cnt_hi   = ^cnt_raw[CNT_IN_W-1:CNT_W];
        flags.zero      = (k == '0);
        flags.over_half = (int'(k) > HALF);
    end

endmodule

// File: rtl/fsh_lane.sv
// Module: fsh_lane
// Combinational funnel shift of one operand width W, both directions.
// Assumes: k >= 1 when the outputs are consumed; k < 2*W.
module fsh_lane
    import fsh_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     dst,
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] k,
    input  sh_dir_e          dir,
    output logic [W-1:0]     res,
    output logic             cout
);

    logic [2*W:0] lvec;
    logic [2*W:0] rvec;
    logic         unused_lo;
    logic         unused_hi;

    // Left: {pad, dst, src} shifted up; top pad bit catches the carry.
    // Right: {src, dst, pad} shifted down; bottom pad bit catches the carry.
    always_comb begin
        lvec      = {1'b0, dst, src} << k;
        rvec      = {src, dst, 1'b0} >> k;
        unused_lo = ^lvec[W-1:0];
        unused_hi = ^rvec[2*W:W+1];
        if (dir == SH_LEFT) begin
            res  = lvec[2*W-1:W];
            cout = lvec[2*W];
        end else begin
            res  = rvec[W:1];
            cout = rvec[0];
        end
    end

endmodule

// File: rtl/fsh_core.sv
// Module: fsh_core
// Instantiates one lane per operand size, selects by size and applies
// the zero-count and out-of-range bypass rules.
// Assumes: DATA_W even; narrow size is DATA_W/2.
module fsh_core
    import fsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  k,
    input  cnt_flags_t        flags,
    input  sh_dir_e           dir,
    input  logic              wide,
    output logic [DATA_W-1:0] nxt_res,
    output logic              nxt_carry,
    output logic              carry_upd,
    output logic              nxt_err
);

    localparam int HALF  = DATA_W / 2;
    localparam int NLANE = 2;

    logic [DATA_W-1:0] lane_res [NLANE];
    logic              lane_c   [NLANE];

    // Lane 0 is the half-width lane, lane 1 the full-width lane.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = HALF << g;
        logic [LW-1:0] r;
        logic          c;
        fsh_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .dst  (dst[LW-1:0]),
            .src  (src[LW-1:0]),
            .k    (k),
            .dir  (dir),
            .res  (r),
            .cout (c)
        );
        if (LW == DATA_W) begin : g_full
            assign lane_res[g] = r;
        end else begin : g_ext
            assign lane_res[g] = {{(DATA_W-LW){1'b0}}, r};
        end
        assign lane_c[g] = c;
    end

    logic [DATA_W-1:0] keep_val;
    logic              bad_cnt;

    // Choose the lane, or pass the destination through unchanged.
    always_comb begin
        keep_val  = wide ? dst : {{(DATA_W-HALF){1'b0}}, dst[HALF-1:0]};
        bad_cnt   = !wide && flags.over_half;
        nxt_err   = bad_cnt;
        if (flags.zero || bad_cnt) begin
            nxt_res   = keep_val;
            nxt_carry = 1'b0;
            carry_upd = 1'b0;
        end else begin
            nxt_res   = lane_res[wide ? 1 : 0];
            nxt_carry = lane_c[wide ? 1 : 0];
            carry_upd = 1'b1;
        end
    end

endmodule

// File: rtl/dfunnel_shifter.sv
// Module: dfunnel_shifter (top)
// Funnel shifter with registered result, carry and error, qualified by
// a one-cycle valid pulse. Carry is held across zero-count and error ops.
// Assumes: DATA_W = 32 gives 16/32-bit operation; CNT_W = log2(DATA_W).
module dfunnel_shifter
    import fsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir_i,
    input  logic              size32_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int HALF  = DATA_W / 2;

    logic [CNT_W-1:0]  k;
    cnt_flags_t        flags;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_carry;
    logic              carry_upd;
    logic              nxt_err;
    sh_dir_e           dir;

    assign dir = sh_dir_e'(dir_i);

    fsh_count #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W), .HALF(HALF)) u_count (
        .cnt_raw (cnt_i),
        .k       (k),
        .flags   (flags)
    );

    fsh_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .dst       (dst_i),
        .src       (src_i),
        .k         (k),
        .flags     (flags),
        .dir       (dir),
        .wide      (size32_i),
        .nxt_res   (nxt_res),
        .nxt_carry (nxt_carry),
        .carry_upd (carry_upd),
        .nxt_err   (nxt_err)
    );

    // Output register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_o     <= '0;
            carry_o   <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_o <= nxt_res;
                err_o <= nxt_err;
                if (carry_upd) begin
                    carry_o <= nxt_carry;
                end
            end
        end
    end

endmodule

// File: rtl/fsh_chk.sv
// Module: fsh_chk
// Port-level properties of dfunnel_shifter, bound to every instance.
// Assumes: same parameters as the top module.
module fsh_chk #(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              size32_i,
    input logic [CNT_IN_W-1:0] cnt_i,
    input logic [DATA_W-1:0] dst_i,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o,
    input logic              err_o
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int HALF  = DATA_W / 2;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_o) && $stable(carry_o) && $stable(err_o)));

    a_r6_zero_count_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size32_i && cnt_i[CNT_W-1:0] == '0)
        |=> (res_o == $past(dst_i) && $stable(carry_o) && !err_o));

    a_r8_over_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size32_i && int'(cnt_i[CNT_W-1:0]) > HALF)
        |=> (err_o && $stable(carry_o)));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size32_i) |=> (res_o[DATA_W-1:HALF] == '0));

endmodule

bind dfunnel_shifter fsh_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_fsh_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size32_i  (size32_i),
    .cnt_i     (cnt_i),
    .dst_i     (dst_i),
    .out_valid (out_valid),
    .res_o     (res_o),
    .carry_o   (carry_o),
    .err_o     (err_o)
);

// File: tb/tb_dfunnel_shifter.sv
`timescale 1ns/1ps
// Bench: behavioural per-bit reference model, compared every clock.
module tb_dfunnel_shifter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        dir_i;
    logic        size32_i;
    logic [7:0]  cnt_i;
    logic [31:0] dst_i;
    logic [31:0] src_i;
    logic        out_valid;
    logic [31:0] res_o;
    logic        carry_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;

    // Model state: what the outputs should be at the next compare.
    logic        e_valid = 1'b0;
    logic [31:0] e_res   = '0;
    logic        e_carry = 1'b0;
    logic        e_err   = 1'b0;
    string       e_tag   = "R10";
    logic [31:0] rng     = 32'h1234_5678;

    always #2 clk = ~clk;

    dfunnel_shifter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_i(dir_i),
        .size32_i(size32_i), .cnt_i(cnt_i), .dst_i(dst_i), .src_i(src_i),
        .out_valid(out_valid), .res_o(res_o), .carry_o(carry_o), .err_o(err_o)
    );

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check_eq("R9", "out_valid", {31'b0, out_valid}, {31'b0, e_valid});
        check_eq(e_tag, "res", res_o, e_res);
        check_eq(e_tag, "carry", {31'b0, carry_o}, {31'b0, e_carry});
        check_eq((e_tag == "R10") ? "R10" : "R8", "err",
                 {31'b0, err_o}, {31'b0, e_err});
    endtask

    // Per-bit behavioural model of the joined-operand shift.
    task automatic model(input logic v, input logic d, input logic s,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] c);
        int k = int'(c[4:0]);
        int w = s ? 32 : 16;
        logic [31:0] am = s ? a : {16'b0, a[15:0]};
        e_valid = v;
        if (!v) return;
        if (k == 0) begin
            e_res = am;
            e_err = 1'b0;
        end else if (!s && k > 16) begin
            e_res = am;
            e_err = 1'b1;
        end else begin
            e_res = '0;
            e_err = 1'b0;
            for (int i = 0; i < w; i++) begin
                if (!d) e_res[i] = (i >= k) ? a[i-k] : b[w-k+i];
                else    e_res[i] = (i + k < w) ? a[i+k] : b[i+k-w];
            end
            e_carry = d ? a[k-1] : a[w-k];
        end
    endtask

    task automatic step(input logic v, input logic d, input logic s,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [7:0] c, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; dir_i = d; size32_i = s;
        dst_i = a; src_i = b; cnt_i = c;
        model(v, d, s, a, b, c);
        if (v) e_tag = tag;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; dir_i = 1'b0; size32_i = 1'b1;
        cnt_i = '0; dst_i = '0; src_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values seen after release.
        step(0, 0, 1, 32'h0, 32'h0, 8'd0, "R10");
        // R1/R3 and R2/R4 with the known operand pair.
        step(1, 0, 1, 32'h01234567, 32'h89ABCDEF, 8'd8, "R1 R3");
        step(1, 1, 1, 32'h01234567, 32'h89ABCDEF, 8'd8, "R2 R4");
        // Set carry to 1, then zero count must hold it (R6).
        step(1, 0, 1, 32'h01234567, 32'h89ABCDEF, 8'd8, "R3");
        step(1, 1, 1, 32'hDEADBEEF, 32'h12345678, 8'd0, "R6");
        step(1, 0, 0, 32'hFFFF1234, 32'h0, 8'd224, "R6 R5");
        // R5: upper count bits ignored (40 masks to 8).
        step(1, 1, 1, 32'h01234567, 32'h89ABCDEF, 8'd40, "R5");
        // R7: 16-bit mode, count 16 and a normal count.
        step(1, 0, 0, 32'hAAAA8001, 32'h5555C3A5, 8'd16, "R7");
        step(1, 1, 0, 32'hAAAA8001, 32'h5555C3A5, 8'd16, "R7");
        step(1, 0, 0, 32'hFFFF8001, 32'hFFFFF0F0, 8'd4, "R7");
        // R8: carry known, then out-of-range 16-bit count.
        step(1, 0, 0, 32'h0000C000, 32'h0, 8'd1, "R8");
        step(1, 1, 0, 32'h9876ABCD, 32'h1111, 8'd20, "R8");
        step(1, 0, 1, 32'h00000001, 32'h0, 8'd31, "R8");
        // R9: idle cycles hold everything.
        step(0, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd3, "R9");
        step(0, 0, 1, 32'h0, 32'h0, 8'd9, "R9");
        // Mixed pseudo-random traffic.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b, r;
            rng = nxt(rng); a = rng;
            rng = nxt(rng); b = rng;
            rng = nxt(rng); r = rng;
            step(r[0] | r[1], r[2], r[3], a, b, r[15:8],
                 r[3] ? (r[2] ? "R2 R4" : "R1 R3") : "R7 R8");
        end
        step(0, 0, 1, 32'h0, 32'h0, 8'd0, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule